// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns memory requests from a processor core into cycles on a multiplexed 16-bit address/data bus. Each request is routed first. The routing uses an external-access select level, which is captured while reset is held, and an address window that covers the on-chip ROM. A request that falls inside the window while the captured level is high completes internally in one cycle and leaves the bus idle. Any other request becomes one or two external bus cycles.

The width of an external cycle comes from a two-bit code. The code can fix every cycle at 8 or 16 bits, or it can let a bus-width pin choose per cycle. A 16-bit access that runs on an 8-bit bus is split into two byte cycles. Each cycle has four one-clock phases. The address strobe is either a one-clock latch-enable pulse or an active-low address-valid level. A write-low mode makes the write strobe fire only when an even byte is written. An instruction-fetch indicator marks external fetches. The core issues one request at a time with a ready/done handshake.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: With width code {cfg_a,cfg_b}=11, the level of width_pin at the clock edge that accepts a request sets the cycle width: 0 gives 8 bits, 1 gives 16 bits.
- R2: Code 01 makes every external cycle 8 bits wide, and code 10 makes every external cycle 16 bits wide. On an 8-bit cycle the data travels on ad[7:0], and a write drives ad[15:8] to zero. On a 16-bit byte write the byte is driven on both lanes.
- R3: Code 00 is illegal. One clock after code 00 is present, cfg_err is 1. Cycles under code 00 are 8 bits wide. cfg_err is 0 one clock after any legal code.
- R4: A word access on an 8-bit cycle runs as two complete bus cycles. The first uses the even address (address bit 0 cleared) and carries the low byte. The second uses the odd address and carries the high byte.
- R5: An external cycle runs ADDR, RELEASE, DATA and END in that order, one clock each. In ADDR, ad_out holds the byte address and ad_oe is 1. In RELEASE, ad_oe is 0. In DATA, a write drives its data with ad_oe at 1.
- R6: With cfg_advl=0, strb is 1 only in the ADDR phase. With cfg_advl=1, strb is 0 from ADDR through DATA and returns to 1 in END.
- R7: While idle, and during internal accesses, rd_n and wr_n are 1 and ad_oe and inst are 0.
- R8: In DATA, rd_n is 0 for reads. wr_n is 0 for writes when cfg_wrlow=0. When cfg_wrlow=1, wr_n is 0 only if the cycle address is even. rd_n and wr_n are never 0 together.
- R9: inst equals req_fetch in every phase of an external cycle. It is 0 during internal accesses.
- R10: ext_sel is captured only while rst is 1. If the captured value is 1 and the address lies in [ROM_LO, ROM_HI], the access is internal: one clock after acceptance, done and int_hit are both 1 and no bus strobe moves. Any other access goes external.
- R11: Read data is sampled in DATA and presented on rdata in END. For 8-bit cycles: a byte read returns {8'h00, ad[7:0]}, and a split word read returns {second byte, first byte}. For 16-bit cycles: a word read returns ad[15:0], and a byte read returns {8'h00, the lane selected by address bit 0 (1 selects ad[15:8])}.
- R12: done is a one-clock pulse in the END phase of the last cycle of an external access. req_ready is 1 only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; ext_sel is captured while high |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 16 | Byte address (even for word accesses) |
| req_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| done | output | 1 | Access complete pulse |
| int_hit | output | 1 | Completed access was served internally |
| rdata | output | 16 | Read data, valid with done |
| cfg_a | input | 1 | Width code bit A |
| cfg_b | input | 1 | Width code bit B |
| cfg_advl | input | 1 | 1 = address-valid level strobe, 0 = latch-enable pulse |
| cfg_wrlow | input | 1 | 1 = write strobe only for even bytes |
| ext_sel | input | 1 | External-access select, captured during reset |
| width_pin | input | 1 | Dynamic bus-width select |
| cfg_err | output | 1 | Illegal width code flag |
| ad_out | output | 16 | Address/data bus output value |
| ad_oe | output | 1 | Address/data bus output enable |
| ad_in | input | 16 | Address/data bus input value |
| strb | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write / write-low strobe, active low |
| inst | output | 1 | External instruction fetch indicator |

## Verification
The bench sets the ROM window to 0x0100..0x01FF. With that window, both edges and both neighbours of the internal range (0x00FF, 0x0100, 0x01FF, 0x0200) can be reached with short addresses. It resets the block twice, once with ext_sel high and once with ext_sel low. This shows that the same window address is routed either way, and that a later change of ext_sel is ignored. It steps through all four width codes, both strobe styles and both write-strobe modes. It covers split word reads and writes, and odd and even byte lanes on both bus widths.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int XB_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_REL,
    PH_DATA,
    PH_END
  } phase_t;
endpackage

// File: rtl/xbc_route.sv
module xbc_route #(
  parameter int W = 16,
  parameter logic [W-1:0] ROM_LO = '0,
  parameter logic [W-1:0] ROM_HI = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_sel,
  input  logic [W-1:0] addr,
  output logic         internal
);
  logic ea_q;

  // external-access level is only sampled while reset is held
  always_ff @(posedge clk) begin
    if (rst) ea_q <= ext_sel;
  end

  assign internal = ea_q && (addr >= ROM_LO) && (addr <= ROM_HI);
endmodule

// File: rtl/xbc_width.sv
module xbc_width (
  input  logic clk,
  input  logic rst,
  input  logic cfg_a,
  input  logic cfg_b,
  input  logic width_pin,
  output logic wide,
  output logic cfg_err
);
  // 11 -> pin decides, 10 -> 16-bit, 01 -> 8-bit, 00 -> illegal, 8-bit
  always_comb begin
    unique case ({cfg_a, cfg_b})
      2'b11:   wide = width_pin;
      2'b10:   wide = 1'b1;
      default: wide = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= !cfg_a && !cfg_b;
  end

  assert_err_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_a && !cfg_b) |=> cfg_err);
  assert_err_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_a || cfg_b) |=> !cfg_err);
endmodule

// File: rtl/xbc_seq.sv
module xbc_seq
  import xbc_pkg::*;
#(
  parameter int W = XB_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic         req_fetch,
  input  logic         req_word,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_wdata,
  input  logic         internal,
  input  logic         wide,
  input  logic         cfg_advl,
  input  logic         cfg_wrlow,
  input  logic [W-1:0] ad_in,
  output logic         done,
  output logic         int_hit,
  output logic [W-1:0] rdata,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  output logic         strb,
  output logic         rd_n,
  output logic         wr_n,
  output logic         inst
);
  localparam int HB = W / 2;

  phase_t       ph;
  logic         op_write, op_word, op_wide, op_ext, op_advl, op_wrlow;
  logic         two, beat;
  logic [W-1:0] base, wdat;
  logic [W-1:0] cur_addr, wdrive;
  logic         wen;

  always_comb begin
    cur_addr = two ? {base[W-1:1], beat} : base;
    wen      = !op_wrlow || !cur_addr[0];
    if (op_wide) wdrive = op_word ? wdat : {wdat[HB-1:0], wdat[HB-1:0]};
    else         wdrive = {{HB{1'b0}}, (op_word && beat) ? wdat[W-1:HB] : wdat[HB-1:0]};
  end

  assign req_ready = (ph == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE;
      done <= 1'b0; int_hit <= 1'b0; rdata <= '0;
      ad_out <= '0; ad_oe <= 1'b0; strb <= 1'b0;
      rd_n <= 1'b1; wr_n <= 1'b1; inst <= 1'b0;
      op_write <= 1'b0; op_word <= 1'b0; op_wide <= 1'b0; op_ext <= 1'b0;
      op_advl <= 1'b0; op_wrlow <= 1'b0; two <= 1'b0; beat <= 1'b0;
      base <= '0; wdat <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          done <= 1'b0; int_hit <= 1'b0;
          strb <= cfg_advl;
          rd_n <= 1'b1; wr_n <= 1'b1; ad_oe <= 1'b0; inst <= 1'b0;
          if (req_valid) begin
            op_write <= req_write; op_word <= req_word; op_wide <= wide;
            op_advl <= cfg_advl; op_wrlow <= cfg_wrlow;
            base <= req_addr; wdat <= req_wdata;
            beat <= 1'b0;
            two  <= req_word && !wide;
            if (internal) begin
              op_ext <= 1'b0;
              ph <= PH_END;
              done <= 1'b1; int_hit <= 1'b1;
            end else begin
              op_ext <= 1'b1;
              ph <= PH_ADDR;
              ad_out <= (req_word && !wide) ? {req_addr[W-1:1], 1'b0} : req_addr;
              ad_oe <= 1'b1;
              strb <= !cfg_advl;
              inst <= req_fetch;
            end
          end
        end
        PH_ADDR: begin
          ph <= PH_REL;
          strb <= 1'b0;
          ad_oe <= 1'b0;
        end
        PH_REL: begin
          ph <= PH_DATA;
          rd_n <= op_write;
          wr_n <= !(op_write && wen);
          ad_oe <= op_write;
          if (op_write) ad_out <= wdrive;
        end
        PH_DATA: begin
          ph <= PH_END;
          rd_n <= 1'b1; wr_n <= 1'b1; ad_oe <= 1'b0;
          strb <= op_advl;
          done <= (beat == two);
          if (!op_write) begin
            if (op_wide)
              rdata <= op_word ? ad_in
                     : {{HB{1'b0}}, base[0] ? ad_in[W-1:HB] : ad_in[HB-1:0]};
            else if (!op_word)
              rdata <= {{HB{1'b0}}, ad_in[HB-1:0]};
            else if (beat)
              rdata[W-1:HB] <= ad_in[HB-1:0];
            else
              rdata[HB-1:0] <= ad_in[HB-1:0];
          end
        end
        PH_END: begin
          done <= 1'b0; int_hit <= 1'b0;
          if (op_ext && two && !beat) begin
            beat <= 1'b1;
            ph <= PH_ADDR;
            ad_out <= {base[W-1:1], 1'b1};
            ad_oe <= 1'b1;
            strb <= !op_advl;
          end else begin
            ph <= PH_IDLE;
            inst <= 1'b0;
            strb <= cfg_advl;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  assert_ale_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_REL) |-> !strb);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE) |-> (rd_n && wr_n && !ad_oe && !inst));
  assert_int_nobus_R10: assert property (@(posedge clk) disable iff (rst)
    int_hit |-> (rd_n && wr_n && !ad_oe && !inst && done));
  assert_phase_order_R5: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_ADDR) |=> (ph == PH_REL));
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbc_pkg::*;
#(
  parameter logic [XB_W-1:0] ROM_LO = 16'h2000,
  parameter logic [XB_W-1:0] ROM_HI = 16'h5FFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_fetch,
  input  logic            req_word,
  input  logic [XB_W-1:0] req_addr,
  input  logic [XB_W-1:0] req_wdata,
  output logic            done,
  output logic            int_hit,
  output logic [XB_W-1:0] rdata,
  input  logic            cfg_a,
  input  logic            cfg_b,
  input  logic            cfg_advl,
  input  logic            cfg_wrlow,
  input  logic            ext_sel,
  input  logic            width_pin,
  output logic            cfg_err,
  output logic [XB_W-1:0] ad_out,
  output logic            ad_oe,
  input  logic [XB_W-1:0] ad_in,
  output logic            strb,
  output logic            rd_n,
  output logic            wr_n,
  output logic            inst
);
  logic internal, wide;

  xbc_route #(.W(XB_W), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)) u_route (
    .clk(clk), .rst(rst), .ext_sel(ext_sel), .addr(req_addr), .internal(internal)
  );

  xbc_width u_width (
    .clk(clk), .rst(rst), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .width_pin(width_pin), .wide(wide), .cfg_err(cfg_err)
  );

  xbc_seq #(.W(XB_W)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_fetch(req_fetch), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .internal(internal), .wide(wide),
    .cfg_advl(cfg_advl), .cfg_wrlow(cfg_wrlow), .ad_in(ad_in),
    .done(done), .int_hit(int_hit), .rdata(rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .strb(strb),
    .rd_n(rd_n), .wr_n(wr_n), .inst(inst)
  );
endmodule

// File: tb/sim_xbus_cycle_ctrl.sv
module sim_xbus_cycle_ctrl;
  localparam logic [15:0] LO = 16'h0100;
  localparam logic [15:0] HI = 16'h01FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, ad_in = '0;
  logic cfg_a = 1'b1, cfg_b = 1'b0, cfg_advl = 1'b0, cfg_wrlow = 1'b0;
  logic ext_sel = 1'b1, width_pin = 1'b0;
  logic req_ready, done, int_hit, cfg_err, ad_oe, strb, rd_n, wr_n, inst;
  logic [15:0] rdata, ad_out;

  int checks = 0;
  int failures = 0;
  bit ea_lvl = 1'b1;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xbus_cycle_ctrl #(.ROM_LO(LO), .ROM_HI(HI)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_fetch(req_fetch), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .int_hit(int_hit),
    .rdata(rdata), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_advl(cfg_advl),
    .cfg_wrlow(cfg_wrlow), .ext_sel(ext_sel), .width_pin(width_pin),
    .cfg_err(cfg_err), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .strb(strb), .rd_n(rd_n), .wr_n(wr_n), .inst(inst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit sel);
    rst = 1'b1; ext_sel = sel; ea_lvl = sel;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // behavioural model of one access, checked on every clock
  task automatic access(input bit w, input bit f, input bit wd,
                        input logic [15:0] a, input logic [15:0] wdat,
                        input logic [15:0] bw, input string tag);
    bit intl, wide, advl, wrl, last;
    int nb;
    logic [15:0] bad, exp_d, exp_r;
    intl = ea_lvl && (a >= LO) && (a <= HI);
    wide = (cfg_a && cfg_b) ? width_pin : (cfg_a && !cfg_b);
    advl = cfg_advl; wrl = cfg_wrlow;
    nb = intl ? 0 : ((wd && !wide) ? 2 : 1);
    chk({tag, " R12 ready idle"}, req_ready, 1);
    req_valid = 1'b1; req_write = w; req_fetch = f; req_word = wd;
    req_addr = a; req_wdata = wdat;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (intl) begin
      chk({tag, " R10 int done"}, done, 1);
      chk({tag, " R10 int_hit"}, int_hit, 1);
      chk({tag, " R7 quiet int"}, {rd_n, wr_n, ad_oe, inst}, 4'b1100);
      chk({tag, " R9 no inst int"}, inst, 0);
      @(negedge clk);
    end else begin
      for (int b = 0; b < nb; b++) begin
        bad = (nb == 2) ? {a[15:1], b[0]} : a;
        last = (b == nb - 1);
        chk({tag, " R5 addr"}, {ad_oe, ad_out}, {1'b1, bad});
        chk({tag, " R6 strb addr"}, strb, advl ? 0 : 1);
        chk({tag, " R9 inst addr"}, inst, f);
        chk({tag, " R10 no int_hit"}, int_hit, 0);
        @(negedge clk);
        chk({tag, " R5 release"}, ad_oe, 0);
        chk({tag, " R6 strb release"}, strb, 0);
        @(negedge clk);
        chk({tag, " R8 rd_n"}, rd_n, w);
        chk({tag, " R8 wr_n"}, wr_n, !(w && (!wrl || !bad[0])));
        chk({tag, " R6 strb data"}, strb, 0);
        chk({tag, " R9 inst data"}, inst, f);
        if (w) begin
          if (wide) exp_d = wd ? wdat : {wdat[7:0], wdat[7:0]};
          else      exp_d = {8'h00, (wd && b == 1) ? wdat[15:8] : wdat[7:0]};
          chk({tag, " R2 write data"}, {ad_oe, ad_out}, {1'b1, exp_d});
        end
        ad_in = wide ? bw : {8'hEE, (b == 1) ? bw[15:8] : bw[7:0]};
        @(negedge clk);
        chk({tag, " R6 strb end"}, strb, advl ? 1 : 0);
        chk({tag, " R12 done"}, done, last);
        chk({tag, " R9 inst end"}, inst, f);
        chk({tag, " R8 strobes end"}, {rd_n, wr_n}, 2'b11);
        if (last && !w) begin
          if (wide) exp_r = wd ? bw : {8'h00, a[0] ? bw[15:8] : bw[7:0]};
          else      exp_r = wd ? bw : {8'h00, bw[7:0]};
          chk({tag, " R11 rdata"}, rdata, exp_r);
        end
        @(negedge clk);
      end
    end
    chk({tag, " R12 done cleared"}, done, 0);
    chk({tag, " R12 ready again"}, req_ready, 1);
    chk({tag, " R7 quiet idle"}, {rd_n, wr_n, ad_oe, inst}, 4'b1100);
    chk({tag, " R6 idle strb"}, strb, advl);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R12 reset ready", req_ready, 1);
    chk("R7 reset quiet", {rd_n, wr_n, ad_oe, inst, done, strb}, 6'b110000);
    do_reset(1'b1);
    chk("R3 legal code no err", cfg_err, 0);

    // fixed 16-bit
    access(0, 0, 1, 16'h0400, 16'h0, 16'hA55A, "R2 c10 word read");
    access(1, 0, 1, 16'h0402, 16'h1234, 16'h0, "R2 c10 word write");
    access(1, 0, 0, 16'h0405, 16'h00C3, 16'h0, "R2 c10 byte write");
    access(0, 0, 0, 16'h0407, 16'h0, 16'h7E81, "R11 c10 odd byte read");
    // routing window edges
    access(0, 1, 1, 16'h0100, 16'h0, 16'h0, "R10 low edge");
    access(0, 1, 1, 16'h01FE, 16'h0, 16'h0, "R10 high edge");
    access(0, 0, 0, 16'h01FF, 16'h0, 16'h0, "R10 last byte");
    access(0, 1, 1, 16'h0200, 16'h0, 16'hBEEF, "R10 R9 above window");
    access(0, 1, 0, 16'h00FF, 16'h0, 16'h0042, "R10 R9 below window");
    // fixed 8-bit
    cfg_a = 1'b0; cfg_b = 1'b1;
    @(negedge clk);
    access(0, 0, 1, 16'h0410, 16'h0, 16'hC0DE, "R4 c01 split read");
    access(1, 0, 1, 16'h0412, 16'hF00D, 16'h0, "R4 c01 split write");
    access(1, 0, 0, 16'h0413, 16'h0099, 16'h0, "R2 c01 odd byte write");
    access(0, 0, 0, 16'h0415, 16'h0, 16'h3355, "R11 c01 byte read");
    // pin-selected width
    cfg_a = 1'b1; cfg_b = 1'b1; width_pin = 1'b0;
    @(negedge clk);
    access(1, 0, 1, 16'h0420, 16'h5A5A, 16'h0, "R1 pin low");
    width_pin = 1'b1;
    access(0, 0, 1, 16'h0422, 16'h0, 16'h9876, "R1 pin high");
    access(0, 0, 0, 16'h0425, 16'h0, 16'hAB12, "R1 R11 pin high odd");
    // address-valid strobe style
    cfg_advl = 1'b1;
    @(negedge clk);
    chk("R6 adv idle high", strb, 1);
    access(0, 1, 1, 16'h0430, 16'h0, 16'h1357, "R6 adv wide");
    width_pin = 1'b0;
    access(0, 0, 1, 16'h0432, 16'h0, 16'h2468, "R6 adv split");
    cfg_advl = 1'b0;
    // write-low mode
    cfg_wrlow = 1'b1;
    access(1, 0, 0, 16'h0441, 16'h0011, 16'h0, "R8 wrl odd byte");
    access(1, 0, 0, 16'h0440, 16'h0022, 16'h0, "R8 wrl even byte");
    access(1, 0, 1, 16'h0444, 16'hAA55, 16'h0, "R8 wrl split");
    width_pin = 1'b1;
    access(1, 0, 1, 16'h0446, 16'h6699, 16'h0, "R8 wrl wide");
    cfg_wrlow = 1'b0;
    // illegal code
    cfg_a = 1'b0; cfg_b = 1'b0;
    @(negedge clk);
    chk("R3 err flag", cfg_err, 1);
    access(0, 0, 1, 16'h0450, 16'h0, 16'h4321, "R3 illegal split");
    cfg_a = 1'b1;
    @(negedge clk);
    chk("R3 err clears", cfg_err, 0);
    // external-access select low, later change ignored
    do_reset(1'b0);
    access(0, 1, 1, 16'h0100, 16'h0, 16'h0F0F, "R10 ea low");
    ext_sel = 1'b1;
    @(negedge clk);
    access(0, 0, 1, 16'h0180, 16'h0, 16'hF0F0, "R10 ea change ignored");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule